// File: doc/BRIEF.md
# In-Memory Compute Mode Controller

This block sits on the command path of one pseudo channel. The channel has sixteen banks, and eight compute units each serve one pair of banks. The controller watches the activate, precharge, read and write commands from an unmodified memory controller and keeps track of one of three operating modes. From the current mode and each incoming command it drives a registered per-bank enable vector, a broadcast step pulse for the compute units, the index of the instruction that pulse executes, and an output-enable for the read data path.

The host changes mode only by sending fixed activate/precharge patterns to reserved rows. Four pattern matchers watch the command stream:

- one leads from single-bank to broadcast mode;
- one leads from broadcast to compute mode;
- one leads from compute back to broadcast mode;
- one leads from broadcast back to single-bank mode.

Each pattern is a parameter holding a list of (command, row) steps, and the bank address is not compared. In single-bank mode the channel behaves as plain memory. In broadcast mode one access reaches one bank behind every compute unit. In compute mode every read or write becomes an instruction step and the data I/O stays off.

Top module: `pim_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (single-bank) and `bank_en`, `cu_step`, `cu_step_idx` and `rdata_oe` are all zero. A reset applied in any mode returns the block to this state.
- R2: In single-bank mode, a command to bank b sets only `bank_en[b]` one cycle later. `rdata_oe` is high in that cycle only when the command was a read. Command codes: 0 activate, 1 precharge, 2 read, 3 write.
- R3: In single-bank mode, the complete `SEQ_TO_BCAST` pattern sets `mode` to 1 (broadcast) in the cycle after its last command.
- R4: In broadcast mode, the complete `SEQ_TO_COMPUTE` pattern sets `mode` to 2 (compute) in the cycle after its last command. Compute mode can only be reached from broadcast mode.
- R5: In compute mode, `SEQ_FROM_COMPUTE` returns `mode` to 1. In broadcast mode, `SEQ_TO_SINGLE` returns `mode` to 0.
- R6: In broadcast mode, a command to bank b enables all eight banks whose bit 0 equals bit 0 of b. These are one bank per compute unit, since unit u serves banks 2u and 2u+1. `rdata_oe` follows a read as in R2.
- R7: In compute mode, every read or write raises `cu_step` for exactly one cycle, one cycle after the command, and enables the same half of the banks as R6. Activate and precharge commands enable that half without a step.
- R8: In compute mode, `rdata_oe` stays low, also for reads.
- R9: A matcher moves one step forward on each command whose code and row equal its next step. Any other command sends it back to step 0, and that same command is not tested against step 0. A pattern belonging to a different mode has no effect on `mode`.
- R10: The last command of a mode-change pattern is not forwarded: `bank_en` is zero in the cycle after it. The earlier commands of the pattern are forwarded normally.
- R11: `cu_step_idx` carries 0 on the first step after compute mode is entered. It then counts up by one on each further step and wraps to 0 after `INSTR_DEPTH`-1.
- R12: A cycle with `cmd_valid` low is followed by a cycle in which `bank_en`, `cu_step` and `rdata_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Command code: 0 activate, 1 precharge, 2 read, 3 write |
| cmd_bank | input | 4 | Addressed bank |
| cmd_row | input | 14 | Row address |
| bank_en | output | 16 | Per-bank enable, registered |
| cu_step | output | 1 | One-cycle broadcast step pulse to all compute units |
| cu_step_idx | output | 3 | Instruction index executed by the current step |
| rdata_oe | output | 1 | Read data output enable |
| mode | output | 2 | Current mode: 0 single-bank, 1 broadcast, 2 compute |

## Verification
The closest interaction is the last command of a mode-change pattern. In one cycle it both completes a matcher and arrives at the access decoder. That command must be withheld from the banks, and the new mode must show in the same sample that shows the empty enable vector. The stimulus table walks all four patterns back to back with ordinary accesses on both sides, so every such cycle is judged on `mode` and `bank_en` together. A second collision is the instruction index. After ten steps the bench leaves compute mode and re-enters it, then checks that the first step after the new entry carries index 0 and not the value left over from the earlier visit.

// File: rtl/pim_mode_pkg.sv
package pim_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_BCAST   = 2'd1,
    MODE_COMPUTE = 2'd2
  } pim_mode_e;

  localparam logic [1:0] OP_ACT = 2'd0;
  localparam logic [1:0] OP_PRE = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam logic [1:0] OP_WR  = 2'd3;

  // Default patterns for a 14-bit row; step 0 sits in the low bits, each step is {op,row}
  localparam logic [63:0] DEF_TO_BCAST   = {OP_PRE, 14'h27FF, OP_ACT, 14'h27FF, OP_PRE, 14'h27FE, OP_ACT, 14'h27FE};
  localparam logic [63:0] DEF_TO_COMPUTE = {OP_PRE, 14'h3FFF, OP_ACT, 14'h3FFF, OP_PRE, 14'h3FFE, OP_ACT, 14'h3FFE};
  localparam logic [63:0] DEF_FROM_COMP  = {OP_PRE, 14'h2FFE, OP_ACT, 14'h2FFE, OP_PRE, 14'h2FFF, OP_ACT, 14'h2FFF};
  localparam logic [63:0] DEF_TO_SINGLE  = {OP_PRE, 14'h1FFE, OP_ACT, 14'h1FFE, OP_PRE, 14'h1FFF, OP_ACT, 14'h1FFF};

endpackage

// File: rtl/pim_seq_match.sv
module pim_seq_match #(
  parameter int ROW_W   = 14,
  parameter int SEQ_LEN = 4,
  parameter logic [SEQ_LEN*(ROW_W+2)-1:0] SEQ = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  output logic             hit
);
  localparam int STEP_W = ROW_W + 2;
  localparam int PTR_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(SEQ_LEN - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [STEP_W-1:0] want;
  logic              match;

  always_comb begin
    want = '0;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (ptr_q == PTR_W'(i)) want = SEQ[i*STEP_W +: STEP_W];
    end
  end

  assign match = en && cmd_valid && ({cmd_op, cmd_row} == want);
  assign hit   = match && (ptr_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ptr_q <= '0;
    end else if (cmd_valid) begin
      if (match && !hit) ptr_q <= ptr_q + 1'b1;
      else               ptr_q <= '0;
    end
  end

  AST_PTR_MOVES_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    (ptr_q != $past(ptr_q) && ptr_q != '0) |-> $past(cmd_valid)) // R9
    else $error("matcher advanced without a command");

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST) // R9
    else $error("matcher step out of range");

endmodule

// File: rtl/pim_mode_fsm.sv
module pim_mode_fsm
  import pim_mode_pkg::*;
#(
  parameter int INSTR_DEPTH = 8,
  localparam int IDX_W = (INSTR_DEPTH > 1) ? $clog2(INSTR_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       hits,      // 0 to_bcast, 1 to_compute, 2 from_compute, 3 to_single
  input  logic             trig_req,
  output pim_mode_e        mode_q,
  output logic [IDX_W-1:0] idx_q
);
  pim_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SINGLE:  if (hits[0]) mode_d = MODE_BCAST;
      MODE_BCAST: begin
        if (hits[1])      mode_d = MODE_COMPUTE;
        else if (hits[3]) mode_d = MODE_SINGLE;
      end
      MODE_COMPUTE: if (hits[2]) mode_d = MODE_BCAST;
      default:      mode_d = MODE_SINGLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_SINGLE;
    else     mode_q <= mode_d;
  end

  always_ff @(posedge clk) begin
    if (rst || (mode_q == MODE_BCAST && hits[1])) begin
      idx_q <= '0;
    end else if (trig_req) begin
      if (idx_q == IDX_W'(INSTR_DEPTH - 1)) idx_q <= '0;
      else                                  idx_q <= idx_q + 1'b1;
    end
  end

  AST_COMPUTE_FROM_BCAST: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_COMPUTE && $past(mode_q) != MODE_COMPUTE) |-> $past(mode_q) == MODE_BCAST) // R4
    else $error("compute mode entered from wrong mode");

  AST_MODE_ENCODING: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'd3) // R3
    else $error("mode register holds unused code");

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(idx_q) < INSTR_DEPTH) // R11
    else $error("instruction index past depth");

  AST_IDX_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q == MODE_COMPUTE) |-> idx_q == '0) // R11
    else $error("instruction index not cleared on compute entry");

endmodule

// File: rtl/pim_bank_decode.sv
module pim_bank_decode
  import pim_mode_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int IDX_W     = 3,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pim_mode_e            mode_i,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [BA_W-1:0]      cmd_bank,
  input  logic                 suppress,
  input  logic [IDX_W-1:0]     idx_i,
  output logic                 trig_req,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic                 cu_step_o,
  output logic [IDX_W-1:0]     cu_idx_o,
  output logic                 rdata_oe_o
);
  logic [NUM_BANKS-1:0] one_mask, half_mask, en_d;
  logic                 oe_d;
  logic                 is_access;

  assign one_mask  = {{(NUM_BANKS-1){1'b0}}, 1'b1} << cmd_bank;
  assign is_access = (cmd_op == OP_RD) || (cmd_op == OP_WR);

  // banks 2u and 2u+1 share unit u; one bank per unit = equal bank bit 0
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_half
    assign half_mask[b] = (cmd_bank[0] == 1'(b % 2));
  end

  always_comb begin
    en_d     = '0;
    oe_d     = 1'b0;
    trig_req = 1'b0;
    if (cmd_valid && !suppress) begin
      unique case (mode_i)
        MODE_SINGLE: begin
          en_d = one_mask;
          oe_d = (cmd_op == OP_RD);
        end
        MODE_BCAST: begin
          en_d = half_mask;
          oe_d = (cmd_op == OP_RD);
        end
        MODE_COMPUTE: begin
          en_d     = half_mask;
          trig_req = is_access;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en_o  <= '0;
      cu_step_o  <= 1'b0;
      cu_idx_o   <= '0;
      rdata_oe_o <= 1'b0;
    end else begin
      bank_en_o  <= en_d;
      cu_step_o  <= trig_req;
      cu_idx_o   <= trig_req ? idx_i : '0;
      rdata_oe_o <= oe_d;
    end
  end

  AST_SINGLE_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_SINGLE) |=> $onehot0(bank_en_o)) // R2
    else $error("single-bank mode enabled several banks");

  AST_BCAST_HALF: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_BCAST && cmd_valid && !suppress) |=> $countones(bank_en_o) == NUM_BANKS/2) // R6
    else $error("broadcast access did not reach half the banks");

  AST_STEP_ONLY_COMPUTE: assert property (@(posedge clk) disable iff (rst)
    cu_step_o |-> $past(mode_i) == MODE_COMPUTE) // R7
    else $error("step pulse outside compute mode");

  AST_COMPUTE_IO_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_COMPUTE) |=> !rdata_oe_o) // R8
    else $error("read output enabled in compute mode");

  AST_FINAL_CMD_DROPPED: assert property (@(posedge clk) disable iff (rst)
    suppress |=> bank_en_o == '0) // R10
    else $error("pattern end forwarded to banks");

endmodule

// File: rtl/pim_mode_ctrl.sv
module pim_mode_ctrl
  import pim_mode_pkg::*;
#(
  parameter int NUM_BANKS   = 16,
  parameter int ROW_W       = 14,
  parameter int SEQ_LEN     = 4,
  parameter int INSTR_DEPTH = 8,
  parameter logic [SEQ_LEN*(ROW_W+2)-1:0] SEQ_TO_BCAST     = DEF_TO_BCAST,
  parameter logic [SEQ_LEN*(ROW_W+2)-1:0] SEQ_TO_COMPUTE   = DEF_TO_COMPUTE,
  parameter logic [SEQ_LEN*(ROW_W+2)-1:0] SEQ_FROM_COMPUTE = DEF_FROM_COMP,
  parameter logic [SEQ_LEN*(ROW_W+2)-1:0] SEQ_TO_SINGLE    = DEF_TO_SINGLE,
  localparam int BA_W  = $clog2(NUM_BANKS),
  localparam int IDX_W = (INSTR_DEPTH > 1) ? $clog2(INSTR_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [BA_W-1:0]      cmd_bank,
  input  logic [ROW_W-1:0]     cmd_row,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic                 cu_step,
  output logic [IDX_W-1:0]     cu_step_idx,
  output logic                 rdata_oe,
  output logic [1:0]           mode
);
  localparam int SEQ_W = SEQ_LEN * (ROW_W + 2);
  localparam logic [SEQ_W-1:0] PATTERNS [4] = '{SEQ_TO_BCAST, SEQ_TO_COMPUTE, SEQ_FROM_COMPUTE, SEQ_TO_SINGLE};
  localparam pim_mode_e        SOURCE   [4] = '{MODE_SINGLE, MODE_BCAST, MODE_COMPUTE, MODE_BCAST};

  pim_mode_e        mode_q;
  logic [3:0]       hits;
  logic             trig_req;
  logic [IDX_W-1:0] idx_q;

  for (genvar g = 0; g < 4; g++) begin : g_match
    pim_seq_match #(
      .ROW_W   (ROW_W),
      .SEQ_LEN (SEQ_LEN),
      .SEQ     (PATTERNS[g])
    ) i_match (
      .clk       (clk),
      .rst       (rst),
      .en        (mode_q == SOURCE[g]),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_row   (cmd_row),
      .hit       (hits[g])
    );
  end

  pim_mode_fsm #(
    .INSTR_DEPTH (INSTR_DEPTH)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .hits     (hits),
    .trig_req (trig_req),
    .mode_q   (mode_q),
    .idx_q    (idx_q)
  );

  pim_bank_decode #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W)
  ) i_decode (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_q),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .suppress   (|hits),
    .idx_i      (idx_q),
    .trig_req   (trig_req),
    .bank_en_o  (bank_en),
    .cu_step_o  (cu_step),
    .cu_idx_o   (cu_step_idx),
    .rdata_oe_o (rdata_oe)
  );

  assign mode = mode_q;

endmodule

// File: tb/test_pim_mode_ctrl.sv
module test_pim_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [3:0]  cmd_bank = 4'd0;
  logic [13:0] cmd_row = 14'd0;
  logic [15:0] bank_en;
  logic        cu_step;
  logic [2:0]  cu_step_idx;
  logic        rdata_oe;
  logic [1:0]  mode;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pim_mode_ctrl i_pim_mode_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .bank_en(bank_en),
    .cu_step(cu_step), .cu_step_idx(cu_step_idx), .rdata_oe(rdata_oe), .mode(mode)
  );

  localparam logic [63:0] P_BCAST  = {2'd1, 14'h27FF, 2'd0, 14'h27FF, 2'd1, 14'h27FE, 2'd0, 14'h27FE};
  localparam logic [63:0] P_COMP   = {2'd1, 14'h3FFF, 2'd0, 14'h3FFF, 2'd1, 14'h3FFE, 2'd0, 14'h3FFE};
  localparam logic [63:0] P_LEAVE  = {2'd1, 14'h2FFE, 2'd0, 14'h2FFE, 2'd1, 14'h2FFF, 2'd0, 14'h2FFF};
  localparam logic [63:0] P_SINGLE = {2'd1, 14'h1FFE, 2'd0, 14'h1FFE, 2'd1, 14'h1FFF, 2'd0, 14'h1FFF};

  // {op, bank, row, expected bank_en, step, oe, mode}
  localparam int NV = 24;
  localparam logic [39:0] VEC [NV] = '{
    {2'd2, 4'd3,  14'h0005, 16'h0008, 1'b0, 1'b1, 2'd0},  // R2 read
    {2'd3, 4'd10, 14'h0005, 16'h0400, 1'b0, 1'b0, 2'd0},  // R2 write
    {2'd0, 4'd0,  14'h27FE, 16'h0001, 1'b0, 1'b0, 2'd0},  // R10 forwarded
    {2'd1, 4'd0,  14'h27FE, 16'h0001, 1'b0, 1'b0, 2'd0},
    {2'd0, 4'd0,  14'h27FF, 16'h0001, 1'b0, 1'b0, 2'd0},
    {2'd1, 4'd0,  14'h27FF, 16'h0000, 1'b0, 1'b0, 2'd1},  // R3 R10
    {2'd2, 4'd5,  14'h0001, 16'hAAAA, 1'b0, 1'b1, 2'd1},  // R6 odd
    {2'd3, 4'd4,  14'h0001, 16'h5555, 1'b0, 1'b0, 2'd1},  // R6 even
    {2'd0, 4'd2,  14'h3FFE, 16'h5555, 1'b0, 1'b0, 2'd1},
    {2'd1, 4'd2,  14'h3FFE, 16'h5555, 1'b0, 1'b0, 2'd1},
    {2'd0, 4'd2,  14'h3FFF, 16'h5555, 1'b0, 1'b0, 2'd1},
    {2'd1, 4'd2,  14'h3FFF, 16'h0000, 1'b0, 1'b0, 2'd2},  // R4
    {2'd2, 4'd1,  14'h0010, 16'hAAAA, 1'b1, 1'b0, 2'd2},  // R7 R8
    {2'd3, 4'd0,  14'h0010, 16'h5555, 1'b1, 1'b0, 2'd2},  // R7
    {2'd0, 4'd0,  14'h0007, 16'h5555, 1'b0, 1'b0, 2'd2},  // R7 no step
    {2'd0, 4'd6,  14'h2FFF, 16'h5555, 1'b0, 1'b0, 2'd2},
    {2'd1, 4'd6,  14'h2FFF, 16'h5555, 1'b0, 1'b0, 2'd2},
    {2'd0, 4'd6,  14'h2FFE, 16'h5555, 1'b0, 1'b0, 2'd2},
    {2'd1, 4'd6,  14'h2FFE, 16'h0000, 1'b0, 1'b0, 2'd1},  // R5
    {2'd2, 4'd7,  14'h0002, 16'hAAAA, 1'b0, 1'b1, 2'd1},
    {2'd0, 4'd9,  14'h1FFF, 16'hAAAA, 1'b0, 1'b0, 2'd1},
    {2'd1, 4'd9,  14'h1FFF, 16'hAAAA, 1'b0, 1'b0, 2'd1},
    {2'd0, 4'd9,  14'h1FFE, 16'hAAAA, 1'b0, 1'b0, 2'd1},
    {2'd1, 4'd9,  14'h1FFE, 16'h0000, 1'b0, 1'b0, 2'd0}   // R5
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [3:0] bank, input logic [13:0] row);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_bank  = bank;
    cmd_row   = row;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_pattern(input logic [63:0] p);
    for (int i = 0; i < 4; i++) issue(p[i*16+14 +: 2], 4'd0, p[i*16 +: 14]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "mode", 32'(mode), 32'd0);
    check("R1", "bank_en", 32'(bank_en), 32'd0);
    check("R1", "step/oe/idx", {28'd0, cu_step, rdata_oe, cu_step_idx}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][39:38], VEC[v][37:34], VEC[v][33:20]);
      check("R2-R10 table", "bank_en", 32'(bank_en), 32'(VEC[v][19:4]));
      check("R7 table", "cu_step", 32'(cu_step), 32'(VEC[v][3]));
      check("R8 table", "rdata_oe", 32'(rdata_oe), 32'(VEC[v][2]));
      check("R3 table", "mode", 32'(mode), 32'(VEC[v][1:0]));
    end

    // R12 idle cycle
    issue(2'd2, 4'd1, 14'd0);
    @(negedge clk);
    check("R12", "bank_en idle", 32'(bank_en), 32'd0);
    check("R12", "oe idle", 32'(rdata_oe), 32'd0);

    // R9 pattern of another mode has no effect
    run_pattern(P_COMP);
    check("R9", "mode after foreign pattern", 32'(mode), 32'd0);
    check("R9", "last cmd forwarded", 32'(bank_en), 32'h0001);

    // R9 broken pattern: interposed read restarts matcher
    issue(2'd0, 4'd0, 14'h27FE);
    issue(2'd1, 4'd0, 14'h27FE);
    issue(2'd2, 4'd2, 14'h0000);
    issue(2'd0, 4'd0, 14'h27FF);
    issue(2'd1, 4'd0, 14'h27FF);
    check("R9", "mode after broken pattern", 32'(mode), 32'd0);
    check("R9", "bank_en after broken pattern", 32'(bank_en), 32'h0001);

    // R9 mismatch at step 1 is not re-tested against step 0
    issue(2'd0, 4'd0, 14'h27FE);
    issue(2'd0, 4'd0, 14'h27FE);
    issue(2'd1, 4'd0, 14'h27FE);
    issue(2'd0, 4'd0, 14'h27FF);
    issue(2'd1, 4'd0, 14'h27FF);
    check("R9", "mode after restart", 32'(mode), 32'd0);

    // R11 index counting and wrap
    run_pattern(P_BCAST);
    run_pattern(P_COMP);
    check("R4", "mode compute", 32'(mode), 32'd2);
    for (int k = 0; k < 10; k++) begin
      issue(2'd2, 4'd0, 14'd0);
      check("R11", "step", 32'(cu_step), 32'd1);
      check("R11", "index", 32'(cu_step_idx), 32'(k % 8));
    end
    run_pattern(P_LEAVE);
    check("R5", "mode back to bcast", 32'(mode), 32'd1);
    run_pattern(P_COMP);
    issue(2'd3, 4'd3, 14'd0);
    check("R11", "index after re-entry", 32'(cu_step_idx), 32'd0);
    check("R8", "oe compute write", 32'(rdata_oe), 32'd0);
    @(negedge clk);
    check("R7", "step one cycle", 32'(cu_step), 32'd0);

    // R1 reset from compute mode
    do_reset();
    check("R1", "mode after mid reset", 32'(mode), 32'd0);
    check("R1", "bank_en after mid reset", 32'(bank_en), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule